// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block holds the interrupt state of a network controller: a latched vector of cause bits and a vector of enable bits. It drives one interrupt line toward the host. Hardware event pulses from the datapath latch their cause bits. Software uses a small 32-bit register bus with four byte offsets. Through these offsets it inspects causes, acknowledges them, forces them for testing, and adds or removes enables one bit at a time.

The interrupt line is high while any latched cause is also enabled. The same condition is returned in the top bit of the cause register. Reading the cause register returns its contents and then empties it. A hardware event that lands in the same cycle as a clear is never lost: the event wins.

Top module: `irq_cause_ctrl`

## Requirements
- R1: Register offsets are 0x00C0 (cause read / write-1-to-clear), 0x00C8 (cause force, write only), 0x00D0 (mask set, reads back the mask) and 0x00D8 (mask clear, write only). A read of a write-only or unmapped offset returns 0.
- R2: A write to 0x00D0 sets each mask bit whose data bit is 1. Bits written 0 keep their value, so this address never disables anything.
- R3: A write to 0x00D8 clears each mask bit whose data bit is 1. Bits written 0 keep their value.
- R4: A write to 0x00C0 clears each cause bit whose data bit is 1. Bits written 0 keep their value, and bit 31 of the written data has no effect.
- R5: A write to 0x00C8 sets each implemented cause bit whose data bit is 1. The interrupt line rises only if such a bit is also enabled in the mask.
- R6: Each cycle, the event input bit at an implemented position sets that cause bit. The positions are 0 transmit written back, 1 transmit queue empty, 2 link change, 4 receive descriptor minimum threshold, 6 receiver overrun, 7 receiver timer, 9 management access done, 15 transmit descriptor low, 16 short packet, 17 ACK frame. Together these form 0x000382D7.
- R7: Cause and mask bits outside 0x000382D7, other than cause bit 31, always read 0 and cannot be set.
- R8: Bit 31 of a cause read is 1 exactly when the interrupt line is high in that cycle. It is never stored.
- R9: A read of 0x00C0 returns the current cause value in the same cycle. The cause bits are cleared on the next clock edge.
- R10: If an event sets a cause bit in the same cycle as a write-1-to-clear or a clearing read, the bit stays set.
- R11: The interrupt output is high exactly when the registered cause and mask vectors share a set bit. It follows register changes in the cycle after the edge that made them.
- R12: After reset, the cause and mask vectors are zero and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of reg_rd |
| evt_i | input | 32 | Hardware event pulses, one bit per cause position |
| irq | output | 1 | Interrupt request to the host |

## Verification
A wrong cause or mask bit reaches the irq pin in the cycle after the edge that stored it, as soon as the other vector has the matching bit set. It also shows on the next read of 0x00C0 or 0x00D0. The bench therefore compares irq in every cycle and compares read data on every read, against a model built from the requirements. A lost event shows up the same way, and so does a clear that takes effect one cycle early or late. A dropped clearing read appears as stale bits on the following cause read.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int DATA_W = 32;

    // implemented cause positions: 0,1,2,4,6,7,9,15,16,17
    localparam logic [DATA_W-1:0] IMPL_MASK = 32'h0003_82D7;

    localparam logic [15:0] OFS_CAUSE_RD  = 16'h00C0;
    localparam logic [15:0] OFS_CAUSE_SET = 16'h00C8;
    localparam logic [15:0] OFS_MASK_SET  = 16'h00D0;
    localparam logic [15:0] OFS_MASK_CLR  = 16'h00D8;

    typedef struct packed {
        logic wr_cause_clr;
        logic wr_cause_set;
        logic wr_mask_set;
        logic wr_mask_clr;
        logic rd_cause;
        logic rd_mask;
    } irq_strobe_t;

    typedef struct packed {
        logic [DATA_W-1:0] cause;
        logic [DATA_W-1:0] mask;
    } irq_state_t;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_ctrl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output irq_strobe_t       strb
);
    localparam int NUM_OFS = 4;
    localparam logic [NUM_OFS*16-1:0] OFS_TABLE =
        {OFS_MASK_CLR, OFS_MASK_SET, OFS_CAUSE_SET, OFS_CAUSE_RD};

    logic [NUM_OFS-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < NUM_OFS; g++) begin : g_hit
            assign hit[g] = (addr == ADDR_W'(OFS_TABLE[g*16 +: 16]));
        end
    endgenerate

    always_comb begin
        strb.wr_cause_clr = wr && hit[0];
        strb.wr_cause_set = wr && hit[1];
        strb.wr_mask_set  = wr && hit[2];
        strb.wr_mask_clr  = wr && hit[3];
        strb.rd_cause     = rd && hit[0];
        strb.rd_mask      = rd && hit[2];
    end
endmodule

// File: rtl/irq_vec_next.sv
module irq_vec_next #(
    parameter int          W    = 32,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] nxt
);
    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            if (KEEP[b]) begin : g_live
                // set is applied after clear: a setting source wins
                assign nxt[b] = set[b] | (cur[b] & ~clr[b]);
            end else begin : g_dead
                assign nxt[b] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
    import irq_ctrl_pkg::*;
(
    input  irq_strobe_t       strb,
    input  logic [DATA_W-1:0] cause,
    input  logic [DATA_W-1:0] mask,
    input  logic              pending,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (strb.rd_cause) begin
            rdata = {pending, cause[DATA_W-2:0]};
        end else if (strb.rd_mask) begin
            rdata = mask;
        end
    end
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [31:0]       evt_i,
    output logic              irq
);
    irq_strobe_t       strb;
    irq_state_t        st_d, st_q;
    logic [DATA_W-1:0] cause_set, cause_clr, cause_nxt;
    logic [DATA_W-1:0] msk_set, msk_clr, mask_nxt;
    logic [DATA_W-1:0] mask_q;
    logic              pending;

    irq_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (reg_addr),
        .wr   (reg_wr),
        .rd   (reg_rd),
        .strb (strb)
    );

    always_comb begin
        cause_set = evt_i | (strb.wr_cause_set ? reg_wdata : '0);
        cause_clr = (strb.wr_cause_clr ? reg_wdata : '0)
                  | (strb.rd_cause ? '1 : '0);
        msk_set   = strb.wr_mask_set ? reg_wdata : '0;
        msk_clr   = strb.wr_mask_clr ? reg_wdata : '0;
    end

    irq_vec_next #(.W(DATA_W), .KEEP(IMPL_MASK)) u_cause_nxt (
        .cur (st_q.cause),
        .set (cause_set),
        .clr (cause_clr),
        .nxt (cause_nxt)
    );

    irq_vec_next #(.W(DATA_W), .KEEP(IMPL_MASK)) u_mask_nxt (
        .cur (st_q.mask),
        .set (msk_set),
        .clr (msk_clr),
        .nxt (mask_nxt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.cause = cause_nxt;
        st_d.mask  = mask_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q  = st_q.mask;
    assign pending = |(st_q.cause & st_q.mask);
    assign irq     = pending;

    irq_rd_mux u_rd (
        .strb    (strb),
        .cause   (st_q.cause),
        .mask    (st_q.mask),
        .pending (pending),
        .rdata   (reg_rdata)
    );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_ctrl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic [31:0]       evt_i,
    input logic              irq,
    input logic [31:0]       mask_q
);
    // R3
    mask_clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFS_MASK_CLR) && reg_wdata == 32'hFFFF_FFFF) |=> !irq);

    // R9
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_wr && reg_addr == ADDR_W'(OFS_CAUSE_RD) && evt_i == 32'h0) |=> !irq);

    // R10
    evt_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|(evt_i & mask_q & IMPL_MASK)) && !(reg_wr && reg_addr == ADDR_W'(OFS_MASK_CLR))) |=> irq);

    // R8
    pending_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_W'(OFS_CAUSE_RD)) |-> (reg_rdata[31] == irq));

    // R7
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> ((reg_rdata[30:0] & ~IMPL_MASK[30:0]) == 31'h0));

    // R2
    mask_set_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFS_MASK_SET)) |=> ((mask_q & $past(mask_q)) == $past(mask_q)));
endmodule

bind irq_cause_ctrl irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_i     (evt_i),
    .irq       (irq),
    .mask_q    (mask_q)
);

// File: tb/irq_cause_ctrl_tb.sv
module irq_cause_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam logic [31:0] IMPL = 32'h0003_82D7;
    localparam logic [15:0] A_CR = 16'h00C0;
    localparam logic [15:0] A_CS = 16'h00C8;
    localparam logic [15:0] A_MS = 16'h00D0;
    localparam logic [15:0] A_MC = 16'h00D8;
    localparam logic [15:0] A_NONE = 16'h00E4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic [31:0]       evt_i = '0;
    logic              irq;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] m_cause = '0;
    logic [31:0] m_mask = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_cause_ctrl #(.ADDR_W(ADDR_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_i     (evt_i),
        .irq       (irq)
    );

    function automatic logic exp_irq();
        return |(m_cause & m_mask);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [15:0] a);
        if (a == A_CR) return {exp_irq(), m_cause[30:0]};
        if (a == A_MS) return m_mask;
        return 32'h0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // one bus cycle; rdata and irq compared before the edge, model advanced after it
    task automatic cyc(input logic [15:0] a, input logic w, input logic r,
                       input logic [31:0] wd, input logic [31:0] ev, input string req);
        logic [31:0] set_v, clr_v;
        @(negedge clk);
        reg_addr = a; reg_wr = w; reg_rd = r; reg_wdata = wd; evt_i = ev;
        #1;
        check("R11", {31'h0, irq}, {31'h0, exp_irq()});
        if (r) check(req, reg_rdata, exp_rd(a));
        set_v = ev | ((w && a == A_CS) ? wd : 32'h0);
        clr_v = ((w && a == A_CR) ? wd : 32'h0) | ((r && a == A_CR) ? 32'hFFFF_FFFF : 32'h0);
        @(posedge clk);
        m_cause = (set_v | (m_cause & ~clr_v)) & IMPL;
        if (w && a == A_MS) m_mask = (m_mask | wd) & IMPL;
        if (w && a == A_MC) m_mask = m_mask & ~wd;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0; evt_i = '0;
    endtask

    task automatic rd(input logic [15:0] a, input string req);
        cyc(a, 1'b0, 1'b1, 32'h0, 32'h0, req);
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        cyc(a, 1'b1, 1'b0, d, 32'h0, "R11");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        #1;
        // R12 reset state
        check("R12", {31'h0, irq}, 32'h0);
        rst_n = 1'b1;
        rd(A_CR, "R12");
        rd(A_MS, "R12");

        // R2 mask bits added one at a time, zeros leave bits alone
        wr(A_MS, 32'h0000_0004);
        wr(A_MS, 32'h0000_0040);
        rd(A_MS, "R2");
        check("R2", m_mask, 32'h0000_0044);
        wr(A_MS, 32'h0000_0000);
        rd(A_MS, "R2");
        // R3 mask clear
        wr(A_MC, 32'h0000_0004);
        rd(A_MS, "R3");
        wr(A_MC, 32'h0000_0000);
        rd(A_MS, "R3");

        // R5 forced cause, not enabled: no irq
        wr(A_CS, 32'h0000_0001);
        rd(A_CR, "R5");
        wr(A_CS, 32'h0000_0001);
        wr(A_MS, 32'h0000_0001);
        rd(A_CR, "R8");
        // R4 write 1 to clear, bit 31 ignored
        wr(A_CS, 32'h0000_0003);
        wr(A_CR, 32'h8000_0001);
        check("R4", m_cause, 32'h0000_0002);
        rd(A_CR, "R4");
        // R9 read cleared the register
        rd(A_CR, "R9");

        // R7 reserved bits
        wr(A_CS, 32'hFFFF_FFFF);
        wr(A_MS, 32'hFFFF_FFFF);
        rd(A_MS, "R7");
        rd(A_CR, "R7");
        // R1 write-only and unmapped offsets read 0
        rd(A_CS, "R1");
        rd(A_MC, "R1");
        rd(A_NONE, "R1");

        // R6 each named event position
        wr(A_MC, 32'hFFFF_FFFF);
        for (int i = 0; i < 32; i++) begin
            cyc(A_NONE, 1'b0, 1'b0, 32'h0, 32'h1 << i, "R6");
            rd(A_CR, "R6");
        end

        // R10 event beats write-clear and clearing read
        wr(A_MS, 32'h0000_0044);
        wr(A_CS, 32'h0000_0040);
        cyc(A_CR, 1'b1, 1'b0, 32'h0000_0040, 32'h0000_0040, "R10");
        check("R10", m_cause, 32'h0000_0040);
        cyc(A_CR, 1'b0, 1'b1, 32'h0, 32'h0000_0004, "R10");
        rd(A_CR, "R10");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            logic [2:0]  sel;
            logic [15:0] a;
            logic [1:0]  op;
            logic [31:0] ev;
            sel = 3'($urandom_range(0, 4));
            case (sel)
                3'd0: a = A_CR;
                3'd1: a = A_CS;
                3'd2: a = A_MS;
                3'd3: a = A_MC;
                default: a = A_NONE;
            endcase
            op = 2'($urandom_range(0, 2));
            ev = ($urandom_range(0, 3) == 0) ? $urandom() : 32'h0;
            cyc(a, op == 2'd1, op == 2'd2, $urandom(), ev, "R8");
        end
        finish_run();
    end
endmodule